// File: doc/BRIEF.md
# Big-endian local memory data port

This block sits between the load/store unit of a 32-bit processor and an on-chip block RAM on a bus with a single master. Each cycle the processor may present one access: an address, a size code, a read/write flag, a sign-extension select and, for stores, write data. The block clears the low address bits to the natural alignment of the access size. It drives the RAM address and a per-lane write enable vector. It spreads byte and halfword store data across every lane so that whichever lanes are enabled carry the right bits.

Lanes are numbered big-endian: byte offset 0 is the most significant lane, bits 31:24, and byte offset 3 is bits 7:0. On a load, the block picks the addressed lanes out of the word the RAM returns, moves them to the low end of the result and extends them to 32 bits with either zeros or copies of the sign bit. Every access takes one clock cycle and has no wait states. The response and its ready pulse appear in the cycle after the request is taken.

Top module: `be_lmem_port`

## Requirements
- R1: The RAM address equals the request address with bit 0 cleared for a halfword (size code 01) and bits 1:0 cleared for a word (size code 10 or 11). A byte (size code 00) leaves the address unchanged.
- R2: On a write, `mem_we` (bit 3 is lane 31:24, bit 0 is lane 7:0) is 1000, 0100, 0010 or 0001 for byte offsets 0 to 3. It is 1100 for halfword offset 0, 0011 for halfword offset 2 and 1111 for a word.
- R3: On a write, a byte value `req_wdata[7:0]` appears on all four lanes of `mem_wdata`. A halfword value `req_wdata[15:0]` appears in both bits 31:16 and bits 15:0. A word is passed through unchanged.
- R4: A load returns the addressed lanes in big-endian order in the low bits of `rsp_rdata`. A byte at offset k comes from bits 31-8k down to 24-8k. A halfword at offset 0 comes from bits 31:16 and one at offset 2 from bits 15:0.
- R5: For byte and halfword loads, `req_signed`=1 fills the upper bits of `rsp_rdata` with the top bit of the loaded value, and `req_signed`=0 fills them with zeros.
- R6: `rsp_ready` is high in exactly the cycle after each accepted request, for reads and writes alike, and stays high across back-to-back requests. A read issued the cycle after a write to the same word returns the written data.
- R7: While `rst_n` is low, `mem_en` stays low and `rsp_ready` is low. A request presented during reset changes no memory and produces no ready pulse.
- R8: A read drives `mem_we` to 0000, so a read leaves memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_signed | input | 1 | 1 = sign-extend load result, 0 = zero-extend |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| rsp_ready | output | 1 | Response valid pulse |
| rsp_rdata | output | 32 | Steered and extended load result |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 4 | RAM lane write enables, bit 3 = bits 31:24 |
| mem_addr | output | 32 | Aligned RAM byte address |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Synchronous RAM read word |

## Verification
Stores are tried at every byte offset and at both halfword offsets with distinct lane values. This exposes lane enables or replication that are reversed to little-endian order or shifted by one lane. A word holding bytes with their top bits set and clear is loaded at every offset and size, both signed and unsigned, so that steering errors and sign-versus-zero fill errors give different results. Misaligned halfword and word addresses show whether the truncation is done. Back-to-back write-then-read, reads followed by read-back, and requests held during reset separate ready timing, stray writes and reset gating.

// File: rtl/be_lmem_pkg.sv
package be_lmem_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } acc_size_e;

  function automatic logic [ADDR_W-1:0] align_addr(logic [ADDR_W-1:0] a, acc_size_e s);
    logic [ADDR_W-1:0] r;
    r = a;
    case (s)
      SZ_BYTE: r = a;
      SZ_HALF: r[0] = 1'b0;
      default: r[OFF_W-1:0] = '0;
    endcase
    return r;
  endfunction

  function automatic logic [LANES-1:0] lane_mask(logic [OFF_W-1:0] off, acc_size_e s);
    case (s)
      SZ_BYTE: return 4'b1000 >> off;
      SZ_HALF: return 4'b1100 >> off;
      default: return '1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] steer_read(logic [DATA_W-1:0] w, logic [OFF_W-1:0] off,
                                                   acc_size_e s, logic sgn);
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] r;
    case (s)
      SZ_BYTE: begin
        sh = w >> (8 * (3 - off));
        r  = {{24{sgn & sh[7]}}, sh[7:0]};
      end
      SZ_HALF: begin
        sh = w >> (8 * (2 - off));
        r  = {{16{sgn & sh[15]}}, sh[15:0]};
      end
      default: begin
        sh = w;
        r  = w;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/be_lmem_req.sv
module be_lmem_req
  import be_lmem_pkg::*;
(
  input  logic              acc_start,
  input  logic              req_write,
  input  acc_size_e         size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [OFF_W-1:0]  lane_off
);
  logic [ADDR_W-1:0] aligned;

  always_comb begin
    aligned  = align_addr(req_addr, size);
    lane_off = aligned[OFF_W-1:0];
    mem_addr = aligned;
    mem_we   = (acc_start && req_write) ? lane_mask(lane_off, size) : '0;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8 * l;
    localparam int HL = (l % 2 == 0) ? 15 : 7;
    always_comb begin
      case (size)
        SZ_BYTE: mem_wdata[HI -: 8] = req_wdata[7:0];
        SZ_HALF: mem_wdata[HI -: 8] = req_wdata[HL -: 8];
        default: mem_wdata[HI -: 8] = req_wdata[HI -: 8];
      endcase
    end
  end
endmodule

// File: rtl/be_lmem_rsp.sv
module be_lmem_rsp
  import be_lmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start,
  input  acc_size_e         size,
  input  logic              req_signed,
  input  logic [OFF_W-1:0]  lane_off,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  acc_size_e        size_q;
  logic             sgn_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ready <= 1'b0;
      size_q    <= SZ_WORD;
      sgn_q     <= 1'b0;
      off_q     <= '0;
    end else begin
      rsp_ready <= acc_start;
      if (acc_start) begin
        size_q <= size;
        sgn_q  <= req_signed;
        off_q  <= lane_off;
      end
    end
  end

  always_comb rsp_rdata = steer_read(mem_rdata, off_q, size_q, sgn_q);
endmodule

// File: rtl/be_lmem_port.sv
module be_lmem_port
  import be_lmem_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic        req_signed,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        mem_en,
  output logic [3:0]  mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  logic             acc_start;
  acc_size_e        size;
  logic [OFF_W-1:0] lane_off;

  assign acc_start = rst_n & req_valid;
  assign size      = acc_size_e'(req_size);
  assign mem_en    = acc_start;

  be_lmem_req u_req (
    .acc_start (acc_start),
    .req_write (req_write),
    .size      (size),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .lane_off  (lane_off)
  );

  be_lmem_rsp u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_start  (acc_start),
    .size       (size),
    .req_signed (req_signed),
    .lane_off   (lane_off),
    .mem_rdata  (mem_rdata),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata)
  );
endmodule

// File: rtl/be_lmem_chk.sv
module be_lmem_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  req_size,
  input logic        req_signed,
  input logic        acc_start,
  input logic        mem_en,
  input logic [3:0]  mem_we,
  input logic [31:0] mem_addr,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata
);
  p_half_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && req_size == 2'b01) |-> (mem_addr[0] == 1'b0));

  p_word_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && req_size[1]) |-> (mem_addr[1:0] == 2'b00));

  p_byte_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && req_write && req_size == 2'b00) |-> ($countones(mem_we) == 1));

  p_zero_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && !req_write && !req_signed && req_size == 2'b00) |=> (rsp_rdata[31:8] == 24'h0));

  p_ready_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> rsp_ready);

  p_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ready);

  p_reset_quiet_r7: assert property (@(posedge clk)
    !rst_n |-> (!mem_en && !rsp_ready));

  p_read_nowe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !req_write) |-> (mem_we == 4'b0000));
endmodule

bind be_lmem_port be_lmem_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_size   (req_size),
  .req_signed (req_signed),
  .acc_start  (acc_start),
  .mem_en     (mem_en),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata)
);

// File: tb/be_lmem_port_test.sv
module be_lmem_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
  logic [1:0]  req_size = 2'b10;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        rsp_ready, mem_en;
  logic [31:0] rsp_rdata, mem_addr, mem_wdata;
  logic [3:0]  mem_we;
  logic [31:0] mem_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] ram [0:255];
  logic [7:0]  shadow [0:1023];

  always #5 clk = ~clk;

  be_lmem_port uut (.*);

  always_ff @(posedge clk) begin
    if (mem_en) begin
      for (int l = 0; l < 4; l++)
        if (mem_we[l]) ram[mem_addr[9:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
      mem_rdata <= ram[mem_addr[9:2]];
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_load(logic [31:0] a, logic [1:0] sz, logic sg);
    logic [9:0] b;
    logic [31:0] v;
    b = a[9:0];
    if (sz == 2'b00) begin
      v = {24'h0, shadow[b]};
      if (sg && v[7]) v[31:8] = '1;
    end else if (sz == 2'b01) begin
      b[0] = 1'b0;
      v = {16'h0, shadow[b], shadow[b+1]};
      if (sg && v[15]) v[31:16] = '1;
    end else begin
      b[1:0] = 2'b00;
      v = {shadow[b], shadow[b+1], shadow[b+2], shadow[b+3]};
    end
    return v;
  endfunction

  task automatic shadow_store(logic [31:0] a, logic [1:0] sz, logic [31:0] d);
    logic [9:0] b;
    b = a[9:0];
    if (sz == 2'b00) shadow[b] = d[7:0];
    else if (sz == 2'b01) begin
      b[0] = 1'b0; shadow[b] = d[15:8]; shadow[b+1] = d[7:0];
    end else begin
      b[1:0] = 2'b00;
      shadow[b] = d[31:24]; shadow[b+1] = d[23:16]; shadow[b+2] = d[15:8]; shadow[b+3] = d[7:0];
    end
  endtask

  task automatic drive(logic w, logic [1:0] sz, logic sg, logic [31:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = w; req_size = sz; req_signed = sg;
    req_addr = a; req_wdata = d;
  endtask

  task automatic finish_cycle(string req);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {31'h0, rsp_ready}, 32'h1);
  endtask

  task automatic do_store(logic [1:0] sz, logic [31:0] a, logic [31:0] d);
    drive(1'b1, sz, 1'b0, a, d);
    shadow_store(a, sz, d);
    finish_cycle("R6 write ready");
  endtask

  task automatic do_load(string req, logic [1:0] sz, logic sg, logic [31:0] a);
    logic [31:0] exp;
    exp = expect_load(a, sz, sg);
    drive(1'b0, sz, sg, a, 32'h0);
    #1 check("R8 read no we", {28'h0, mem_we}, 32'h0);
    finish_cycle("R6 read ready");
    check(req, rsp_rdata, exp);
  endtask

  task automatic t_reset;
    check("R7 ready in reset", {31'h0, rsp_ready}, 32'h0);
    drive(1'b1, 2'b10, 1'b0, 32'h10, 32'hDEADBEEF);
    repeat (3) begin
      @(negedge clk);
      check("R7 no mem_en in reset", {31'h0, mem_en}, 32'h0);
      check("R7 no ready in reset", {31'h0, rsp_ready}, 32'h0);
    end
    req_valid = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R7 idle after reset", {31'h0, rsp_ready}, 32'h0);
    do_load("R7 reset write dropped", 2'b10, 1'b0, 32'h10);
  endtask

  task automatic t_align;
    logic [31:0] a [4] = '{32'h103, 32'h102, 32'h101, 32'h100};
    foreach (a[i]) begin
      drive(1'b0, 2'b00, 1'b0, a[i], 0); #1 check("R1 byte addr", mem_addr, a[i]);
      drive(1'b0, 2'b01, 1'b0, a[i], 0); #1 check("R1 half addr", mem_addr, a[i] & 32'hFFFF_FFFE);
      drive(1'b0, 2'b10, 1'b0, a[i], 0); #1 check("R1 word addr", mem_addr, a[i] & 32'hFFFF_FFFC);
      drive(1'b0, 2'b11, 1'b0, a[i], 0); #1 check("R1 word alt addr", mem_addr, a[i] & 32'hFFFF_FFFC);
      req_valid = 1'b0;
    end
  endtask

  task automatic t_write_lanes;
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, 2'b00, 1'b0, 32'h20 + k, 32'hFFFF_FF10 + k);
      #1 check("R2 byte we", {28'h0, mem_we}, {28'h0, 4'b1000 >> k});
      check("R3 byte replicate", mem_wdata, {4{8'h10 + 8'(k)}});
      shadow_store(32'h20 + k, 2'b00, 32'h10 + k);
      finish_cycle("R6 byte write ready");
    end
    do_load("R2 byte lanes stored", 2'b10, 1'b0, 32'h20);
    for (int k = 0; k < 2; k++) begin
      drive(1'b1, 2'b01, 1'b0, 32'h30 + 2*k + 1, 32'hABCD_5A00 + k);
      #1 check("R2 half we", {28'h0, mem_we}, {28'h0, (k == 0) ? 4'b1100 : 4'b0011});
      check("R3 half replicate", mem_wdata, {2{16'h5A00 + 16'(k)}});
      shadow_store(32'h30 + 2*k, 2'b01, 32'h5A00 + k);
      finish_cycle("R6 half write ready");
    end
    do_load("R2 half lanes stored", 2'b10, 1'b0, 32'h30);
    drive(1'b1, 2'b10, 1'b0, 32'h43, 32'h1234_5678);
    #1 check("R2 word we", {28'h0, mem_we}, 32'hF);
    check("R3 word pass", mem_wdata, 32'h1234_5678);
    shadow_store(32'h40, 2'b10, 32'h1234_5678);
    finish_cycle("R6 word write ready");
    do_load("R3 word stored", 2'b10, 1'b0, 32'h40);
  endtask

  task automatic t_read_steer;
    do_store(2'b10, 32'h50, 32'h81_7F_C3_24);
    for (int k = 0; k < 4; k++) begin
      do_load("R4 byte unsigned", 2'b00, 1'b0, 32'h50 + k);
      do_load("R5 byte signed", 2'b00, 1'b1, 32'h50 + k);
    end
    for (int k = 0; k < 2; k++) begin
      do_load("R4 half unsigned", 2'b01, 1'b0, 32'h50 + 2*k);
      do_load("R5 half signed", 2'b01, 1'b1, 32'h51 + 2*k);
    end
    do_load("R4 word signed flag ignored", 2'b10, 1'b1, 32'h52);
    check("R5 expected model sanity", expect_load(32'h50, 2'b00, 1'b1), 32'hFFFF_FF81);
  endtask

  task automatic t_back_to_back;
    drive(1'b1, 2'b00, 1'b0, 32'h61, 32'hEE);
    shadow_store(32'h61, 2'b00, 32'hEE);
    @(posedge clk);
    @(negedge clk);
    check("R6 b2b ready 1", {31'h0, rsp_ready}, 32'h1);
    drive(1'b0, 2'b10, 1'b0, 32'h60, 0);
    @(posedge clk);
    @(negedge clk);
    check("R6 b2b ready 2", {31'h0, rsp_ready}, 32'h1);
    check("R6 read after write", rsp_rdata, expect_load(32'h60, 2'b10, 1'b0));
    req_valid = 1'b0;
    @(negedge clk);
    check("R6 ready drops", {31'h0, rsp_ready}, 32'h0);
  endtask

  task automatic t_read_no_write;
    do_store(2'b10, 32'h70, 32'hCAFE_F00D);
    for (int k = 0; k < 4; k++) begin
      req_wdata = 32'hFFFF_FFFF;
      do_load("R8 byte read", 2'b00, 1'b1, 32'h70 + k);
    end
    do_load("R8 contents unchanged", 2'b10, 1'b0, 32'h70);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = '0;
    for (int i = 0; i < 1024; i++) shadow[i] = '0;
    mem_rdata = '0;
    t_reset();
    t_align();
    t_write_lanes();
    t_read_steer();
    t_back_to_back();
    t_read_no_write();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule